// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Sequencer

This block scans a multiplexed liquid-crystal panel with four common lines and twenty segment lines, which gives 80 addressable segments. Drive levels leave the block as 2-bit codes for low, mid and high, plus a code for an undriven pin. The analog stage that turns these codes into voltages sits outside the block. A single-cycle enable at the crystal rate, nominally 75 kHz, paces the scan. With the default divider of 125 enables per half-phase and eight half-phases per frame, the frame rate is 75 Hz.

Segment patterns come in over a valid/ready write stream. Each beat carries an operation, a digit index (one segment pin) and four bits, one for each common. A beat can write a digit directly into the pending image. It can also stage the digit, and a later commit beat moves every staged digit into the pending image at once. The pending image reaches the panel only at a frame boundary. The stream has one back-pressure rule: `wr_ready` is low during reset and during backup. A beat moves only in a cycle where both `wr_valid` and `wr_ready` are high, and a held beat stays on the bus until it is accepted. Eight of the segment pins can be handed to general-purpose I/O one pin at a time. While backup is held, every driven line goes low and the scan stops. When backup is released, the scan starts again from the beginning of a frame with the stored patterns intact.

Top module: `lcd_quad_seq`

## Requirements
- R1: While `rst_n` is low, every common and every segment not handed to I/O has code LOW (0), and the pending, staged and displayed images are cleared to zero.
- R2: After reset or backup, outputs stay LOW until the first `tick`. That tick starts half-phase 0. Each half-phase then lasts HALF_DIV ticks, and a frame has eight half-phases. Common k is selected in half-phases 2k and 2k+1.
- R3: While scanning, the selected common has code HIGH (2) in its even half-phase and LOW (0) in its odd half-phase. Every other common has code MID (1).
- R4: While scanning, a segment that is on is driven to the rail opposite the selected common: LOW in an even half-phase and HIGH in an odd one. A segment that is off is driven to the same rail as the selected common.
- R5: Bit k of digit d sets the state of segment pin d while common k is selected.
- R6: The displayed image is loaded from the pending image only on the tick that starts a scan or ends half-phase 7. A write made in the middle of a frame shows from the next frame on.
- R7: A beat with op 0 (direct) sets the digit's pending bits.
- R8: A beat with op 1 (stage) holds the digit in a staging image, with no effect on the pending image. A beat with op 2 (commit) copies every digit staged since the last commit into the pending image and clears the staged marks. Op 3 has no effect.
- R9: When bit i of `io_sel` is 1, segment pin IO_BASE+i has code OFF (3) in every mode, including reset and backup. When the bit is 0, the pin is a normal segment.
- R10: In the cycle that `backup` is high, all commons and all segment-mode pins have code LOW. The scan restarts at half-phase 0 on the first tick after backup is released, and the stored images are kept.
- R11: `wr_ready` equals `rst_n` AND NOT `backup`. A direct or stage beat whose digit index is NUM_SEG or above is accepted and dropped.
- R12: No output code changes between ticks unless `backup` or `io_sel` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the crystal rate |
| backup | input | 1 | Backup mode: drive low and stop the scan |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted |
| wr_op | input | 2 | 0 direct, 1 stage, 2 commit, 3 none |
| wr_digit | input | DIG_W | Segment pin index |
| wr_bits | input | NUM_COM | One bit for each common, 1 = on |
| io_sel | input | IO_PINS | 1 hands pin IO_BASE+i to general I/O |
| com_lvl | output | 2*NUM_COM | Level code of each common, common k at bits 2k+1:2k |
| seg_lvl | output | 2*NUM_SEG | Level code of each segment pin, pin d at bits 2d+1:2d |

## Verification
The bench builds the block with 20 segments, 4 commons, an I/O window of eight pins starting at pin 12, and HALF_DIV set to 3. The short divider makes a frame 24 ticks long, so the bench can run hundreds of frames. These include frame-boundary loads that race mid-frame writes, commits that land just before a wrap, and backup entered at every possible half-phase. The bench compares every output code in every cycle with a model built from the requirements. It uses both dense and sparse tick patterns.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_OFF  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_STAGE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_NONE   = 2'd3
  } wop_e;
endpackage

// File: rtl/lcd_seq_timebase.sv
module lcd_seq_timebase #(
  parameter int NUM_COM  = 4,
  parameter int HALF_DIV = 125,
  localparam int PH_W    = $clog2(2 * NUM_COM),
  localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            backup,
  output logic            run_o,
  output logic [PH_W-1:0] phase_o,
  output logic            frame_load_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * NUM_COM - 1);

  logic             run_q;
  logic [CNT_W-1:0] hcnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             half_end;

  assign half_end = run_q && (hcnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hcnt_q <= '0;
      ph_q   <= '0;
    end else if (backup) begin
      run_q  <= 1'b0;
      hcnt_q <= '0;
      ph_q   <= '0;
    end else if (tick) begin
      if (!run_q) begin
        run_q <= 1'b1;
      end else if (half_end) begin
        hcnt_q <= '0;
        ph_q   <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign frame_load_o = rst_n && !backup && tick &&
                        (!run_q || (half_end && ph_q == PH_LAST));
  assign run_o        = run_q;
  assign phase_o      = ph_q;
endmodule

// File: rtl/lcd_seq_store.sv
module lcd_seq_store
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 20,
  parameter int NUM_COM = 4,
  localparam int DIG_W  = $clog2(NUM_SEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_load,
  input  logic                       wr_fire,
  input  logic [1:0]                 wr_op,
  input  logic [DIG_W-1:0]           wr_digit,
  input  logic [NUM_COM-1:0]         wr_bits,
  output logic [NUM_SEG*NUM_COM-1:0] active_o
);
  logic [NUM_COM-1:0] pend_q  [NUM_SEG];
  logic [NUM_COM-1:0] stage_q [NUM_SEG];
  logic [NUM_COM-1:0] act_q   [NUM_SEG];
  logic [NUM_SEG-1:0] mark_q;
  logic               do_direct, do_stage, do_commit, in_range;

  assign in_range  = int'(wr_digit) < NUM_SEG;
  assign do_direct = wr_fire && (wr_op == OP_DIRECT) && in_range;
  assign do_stage  = wr_fire && (wr_op == OP_STAGE)  && in_range;
  assign do_commit = wr_fire && (wr_op == OP_COMMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_q <= '0;
      for (int i = 0; i < NUM_SEG; i++) begin
        pend_q[i]  <= '0;
        stage_q[i] <= '0;
        act_q[i]   <= '0;
      end
    end else begin
      if (do_commit) mark_q <= '0;
      for (int i = 0; i < NUM_SEG; i++) begin
        if (frame_load) act_q[i] <= pend_q[i];
        if (do_commit && mark_q[i]) begin
          pend_q[i] <= stage_q[i];
        end else if (do_direct && wr_digit == DIG_W'(i)) begin
          pend_q[i] <= wr_bits;
        end
        if (do_stage && wr_digit == DIG_W'(i)) begin
          stage_q[i] <= wr_bits;
          mark_q[i]  <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_flat
    assign active_o[g*NUM_COM +: NUM_COM] = act_q[g];
  end
endmodule

// File: rtl/lcd_seq_drive.sv
module lcd_seq_drive
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 20,
  parameter int NUM_COM = 4,
  parameter int IO_BASE = 12,
  parameter int IO_PINS = 8,
  localparam int PH_W   = $clog2(2 * NUM_COM),
  localparam int CSEL_W = PH_W - 1
) (
  input  logic                       run,
  input  logic                       backup,
  input  logic [PH_W-1:0]            phase,
  input  logic [NUM_SEG*NUM_COM-1:0] active,
  input  logic [IO_PINS-1:0]         io_sel,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);
  logic              drv_en;
  logic              odd_half;
  logic [CSEL_W-1:0] com_idx;
  lvl_e              sel_rail, anti_rail;

  assign drv_en    = run && !backup;
  assign odd_half  = phase[0];
  assign com_idx   = phase[PH_W-1:1];
  assign sel_rail  = odd_half ? LVL_LOW : LVL_HIGH;
  assign anti_rail = odd_half ? LVL_HIGH : LVL_LOW;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (!drv_en)                      com_lvl[2*c +: 2] = LVL_LOW;
      else if (com_idx == CSEL_W'(c))   com_lvl[2*c +: 2] = sel_rail;
      else                              com_lvl[2*c +: 2] = LVL_MID;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] bits;
    logic               lit;
    lvl_e               scan_lvl;
    assign bits     = active[s*NUM_COM +: NUM_COM];
    assign lit      = bits[com_idx];
    assign scan_lvl = !drv_en ? LVL_LOW : (lit ? anti_rail : sel_rail);
    if (s >= IO_BASE && s < IO_BASE + IO_PINS) begin : g_shared
      assign seg_lvl[2*s +: 2] = io_sel[s-IO_BASE] ? LVL_OFF : scan_lvl;
    end else begin : g_plain
      assign seg_lvl[2*s +: 2] = scan_lvl;
    end
  end
endmodule

// File: rtl/lcd_quad_seq.sv
module lcd_quad_seq #(
  parameter int NUM_SEG  = 20,
  parameter int NUM_COM  = 4,
  parameter int HALF_DIV = 125,
  parameter int IO_BASE  = 12,
  parameter int IO_PINS  = 8,
  localparam int DIG_W   = $clog2(NUM_SEG),
  localparam int PH_W    = $clog2(2 * NUM_COM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 backup,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [1:0]           wr_op,
  input  logic [DIG_W-1:0]     wr_digit,
  input  logic [NUM_COM-1:0]   wr_bits,
  input  logic [IO_PINS-1:0]   io_sel,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  logic                       run;
  logic [PH_W-1:0]            phase;
  logic                       frame_load;
  logic [NUM_SEG*NUM_COM-1:0] active;

  assign wr_ready = rst_n && !backup;

  lcd_seq_timebase #(.NUM_COM(NUM_COM), .HALF_DIV(HALF_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .backup(backup),
    .run_o(run), .phase_o(phase), .frame_load_o(frame_load)
  );

  lcd_seq_store #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_store (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
    .wr_fire(wr_valid && wr_ready), .wr_op(wr_op),
    .wr_digit(wr_digit), .wr_bits(wr_bits), .active_o(active)
  );

  lcd_seq_drive #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM),
                  .IO_BASE(IO_BASE), .IO_PINS(IO_PINS)) u_drv (
    .run(run), .backup(backup), .phase(phase), .active(active),
    .io_sel(io_sel), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_quad_seq_chk.sv
module lcd_quad_seq_chk
  import lcd_seq_pkg::*;
#(
  parameter int NUM_SEG = 20,
  parameter int NUM_COM = 4,
  parameter int IO_BASE = 12,
  parameter int IO_PINS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 backup,
  input logic                 wr_ready,
  input logic [IO_PINS-1:0]   io_sel,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl
);
  logic [NUM_COM-1:0] not_mid;
  for (genvar c = 0; c < NUM_COM; c++) begin : g_nm
    assign not_mid[c] = com_lvl[2*c +: 2] != LVL_MID;
  end

  AST_BACKUP_COM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> (com_lvl == '0)); // R10

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> !wr_ready); // R11

  AST_ONE_COM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!backup && com_lvl != '0) |-> ($countones(not_mid) == 1)); // R3

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !backup) |=> ($stable(com_lvl) || backup)); // R12

  for (genvar i = 0; i < IO_PINS; i++) begin : g_rel
    AST_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel[i] |-> (seg_lvl[2*(IO_BASE+i) +: 2] == LVL_OFF)); // R9
  end
endmodule

bind lcd_quad_seq lcd_quad_seq_chk #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .IO_BASE(IO_BASE), .IO_PINS(IO_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .backup(backup), .wr_ready(wr_ready),
  .io_sel(io_sel), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_quad_seq_bench.sv
module lcd_quad_seq_bench;
  localparam int NS = 20;
  localparam int NC = 4;
  localparam int DIV = 3;
  localparam int IOB = 12;
  localparam int IOP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, backup = 1'b0, wr_valid = 1'b0;
  logic [1:0] wr_op = 2'd0;
  logic [4:0] wr_digit = '0;
  logic [3:0] wr_bits = '0;
  logic [7:0] io_sel = '0;
  logic wr_ready;
  logic [7:0] com_lvl;
  logic [39:0] seg_lvl;

  always #2 clk = ~clk;

  lcd_quad_seq #(.NUM_SEG(NS), .NUM_COM(NC), .HALF_DIV(DIV),
                 .IO_BASE(IOB), .IO_PINS(IOP)) u_lcd_quad_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .backup(backup),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_op(wr_op),
    .wr_digit(wr_digit), .wr_bits(wr_bits), .io_sel(io_sel),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // requirement-level model
  bit m_run; int m_hc, m_ph;
  logic [3:0] m_pend [NS];
  logic [3:0] m_stage[NS];
  logic [3:0] m_act  [NS];
  bit m_mark [NS];

  function automatic logic [7:0] exp_com();
    logic [7:0] v;
    for (int c = 0; c < NC; c++) begin
      if (!m_run || backup) v[2*c +: 2] = 2'd0;
      else if (c == m_ph / 2) v[2*c +: 2] = (m_ph % 2) ? 2'd0 : 2'd2;
      else v[2*c +: 2] = 2'd1;
    end
    return v;
  endfunction

  function automatic logic [39:0] exp_seg();
    logic [39:0] v;
    for (int s = 0; s < NS; s++) begin
      bit odd = (m_ph % 2) == 1;
      bit on;
      on = m_act[s][m_ph / 2];
      if (s >= IOB && s < IOB + IOP && io_sel[s-IOB]) v[2*s +: 2] = 2'd3;
      else if (!m_run || backup) v[2*s +: 2] = 2'd0;
      else if (on) v[2*s +: 2] = odd ? 2'd2 : 2'd0;
      else v[2*s +: 2] = odd ? 2'd0 : 2'd2;
    end
    return v;
  endfunction

  task automatic model_edge();
    bit load, acc;
    if (!rst_n) begin
      m_run = 0; m_hc = 0; m_ph = 0;
      for (int i = 0; i < NS; i++) begin
        m_pend[i] = 0; m_stage[i] = 0; m_act[i] = 0; m_mark[i] = 0;
      end
      return;
    end
    load = !backup && tick && (!m_run || (m_hc == DIV-1 && m_ph == 2*NC-1));
    if (load) for (int i = 0; i < NS; i++) m_act[i] = m_pend[i];
    acc = wr_valid && !backup;
    if (acc) begin
      if (wr_op == 2'd0 && wr_digit < NS) m_pend[wr_digit] = wr_bits;
      else if (wr_op == 2'd1 && wr_digit < NS) begin
        m_stage[wr_digit] = wr_bits; m_mark[wr_digit] = 1;
      end else if (wr_op == 2'd2) begin
        for (int i = 0; i < NS; i++) if (m_mark[i]) begin
          m_pend[i] = m_stage[i]; m_mark[i] = 0;
        end
      end
    end
    if (backup) begin m_run = 0; m_hc = 0; m_ph = 0; end
    else if (tick) begin
      if (!m_run) m_run = 1;
      else if (m_hc == DIV-1) begin m_hc = 0; m_ph = (m_ph + 1) % (2*NC); end
      else m_hc++;
    end
  endtask

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    #1;
    check(cur_req, "com_lvl", 64'(com_lvl), 64'(exp_com()));
    check(cur_req, "seg_lvl", 64'(seg_lvl), 64'(exp_seg()));
    check("R11", "wr_ready", 64'(wr_ready), 64'(rst_n && !backup));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(int n, bit tk);
    for (int i = 0; i < n; i++) begin
      tick = tk; wr_valid = 0; step();
    end
    tick = 0;
  endtask

  task automatic put(logic [1:0] op, int dig, logic [3:0] b, bit tk);
    wr_valid = 1; wr_op = op; wr_digit = 5'(dig); wr_bits = b; tick = tk;
    step();
    wr_valid = 0; tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7715));
    @(negedge clk);
    cur_req = "R1"; rst_n = 0; idle(5, 1);
    rst_n = 1;
    cur_req = "R12"; idle(6, 0);
    cur_req = "R7";
    for (int d = 0; d < NS; d++) put(2'd0, d, 4'(d) ^ 4'h5, 0);
    cur_req = "R2"; idle(1, 1); idle(6, 0);
    for (int i = 0; i < 30; i++) begin tick = i[0]; step(); end
    cur_req = "R3"; idle(2*NC*DIV + 3, 1);
    cur_req = "R5";
    for (int d = 0; d < NS; d++) put(2'd0, d, 4'(1 << (d % 4)), 1);
    idle(2*NC*DIV, 1);
    cur_req = "R4";
    for (int d = 0; d < NS; d++) put(2'd0, d, 4'hF, 1);
    idle(2*NC*DIV + 2, 1);
    cur_req = "R6"; idle(7, 1);
    put(2'd0, 3, 4'h0, 1); put(2'd0, 9, 4'h6, 1);
    idle(3*NC*DIV, 1);
    cur_req = "R8";
    put(2'd1, 0, 4'hA, 1); put(2'd1, 1, 4'h3, 1); put(2'd1, 19, 4'h9, 1);
    idle(2*NC*DIV, 1);
    put(2'd3, 0, 4'h0, 1);
    idle(2*NC*DIV, 1);
    put(2'd2, 0, 4'h0, 1);
    idle(3*NC*DIV, 1);
    put(2'd2, 0, 4'h0, 1);
    idle(NC*DIV, 1);
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin
      io_sel = 8'($urandom); idle(9, 1);
    end
    backup = 1; io_sel = 8'hA5; idle(4, 1); backup = 0;
    cur_req = "R10"; idle(10, 1);
    backup = 1; put(2'd0, 5, 4'hC, 1); put(2'd1, 6, 4'h1, 0); idle(3, 1);
    backup = 0; idle(3, 0); idle(2*NC*DIV + 4, 1);
    cur_req = "R11";
    for (int d = NS; d < 32; d++) put(2'(d % 2), d, 4'hF, 1);
    put(2'd2, 0, 4'h0, 1);
    idle(3*NC*DIV, 1);
    cur_req = "R1"; rst_n = 0; idle(3, 1); rst_n = 1; idle(2*NC*DIV, 1);
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      backup = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 99) == 0) io_sel = 8'($urandom);
      wr_valid = ($urandom_range(0, 2) == 0);
      wr_op = 2'($urandom); wr_digit = 5'($urandom_range(0, 23));
      wr_bits = 4'($urandom);
      step();
    end
    wr_valid = 0; backup = 0; tick = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule